// File: doc/BRIEF.md
# Paged SPI Flash Program Buffer

This block collects up to one flash page (256 bytes) from a host byte stream into a local buffer. It then sends that page to a SPI flash device as a single page-program frame. The host uses a small byte-wide register port. On that port it sets the 24-bit target address, the program opcode and the transfer length (stored as length minus one). It arms the block through a mode register, pushes the bytes through a data-port register and starts the transfer. It then polls the mode register: one status bit tells it when the buffer can take a new page, and another tells it when the frame has gone out.

On its other side, the block drives a byte-level stream towards a shared SPI master. The master is held for the whole frame by a frame-enable output. Each byte is offered with a valid signal and is taken when the master returns ready. Erase, read-back and automatic sequencing of several pages are left to the host.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset the mode register (0x6F) reads 0x10, the length register (0x71) reads 0xFF, the opcode register (0x6D) reads 0x02, the address registers read 0x00, and `spi_frame` is low.
- R2: Register writes land at fixed offsets and read back unchanged: 0x64 holds address bits [23:16], 0x65 holds bits [15:8], 0x66 holds bits [7:0], 0x6D holds the opcode, and 0x71 holds the byte count minus one. Unmapped offsets and the data port (0x70) read 0x00.
- R3: Writing 0x80 to 0x6F enters programming mode, and mode bit 7 then reads 1. Writing 0x00 leaves programming mode. Outside programming mode, data-port bytes and the start command 0xA0 are ignored.
- R4: In programming mode, bytes written to 0x70 are stored in arrival order. Bytes beyond length+1 are discarded, so the frame carries exactly length+1 data bytes.
- R5: Mode bit 4 (buffer empty) is 1 after reset. It goes to 0 when the first data byte is accepted and returns to 1 when the program frame completes.
- R6: Writing 0xA0 to 0x6F in programming mode starts a frame. Mode bit 5 and `spi_frame` stay 1 from the next cycle until the last byte of the frame is accepted, then both read 0.
- R7: The frame is, in order: the opcode, address [23:16], address [15:8], address [7:0], then buffer bytes 0 through length.
- R8: While `spi_tx_valid` is high and `spi_tx_ready` is low, `spi_tx_valid` and `spi_tx_data` hold their values.
- R9: While a frame is in progress, all register-port writes are ignored, including address, length, opcode, mode and data-port writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| spi_frame | output | 1 | Holds the SPI master and chip select for the whole frame |
| spi_tx_valid | output | 1 | A frame byte is offered |
| spi_tx_data | output | 8 | The frame byte offered |
| spi_tx_ready | input | 1 | The SPI master takes the offered byte |

## Verification
The hardest situation to reach from the ports is a full 256-byte page sent under heavy master back-pressure. In that case the byte index has to run past 255 without wrapping into the header bytes. The stimulus programs length 0xFF and pushes 260 bytes, so that the last four must be dropped. It then starts the frame while the ready signal stalls in a repeating pattern. A second hard case is a register write arriving in the middle of a frame. The bench aims address, mode and data-port writes into the busy window, and checks afterwards that the readback and the next frame's contents show no trace of them.

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int DEPTH = 256,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_frame,
  output logic       spi_tx_valid,
  output logic [7:0] spi_tx_data,
  input  logic       spi_tx_ready
);
  localparam logic [7:0] OFS_A2   = 8'h64;
  localparam logic [7:0] OFS_A1   = 8'h65;
  localparam logic [7:0] OFS_A0   = 8'h66;
  localparam logic [7:0] OFS_OP   = 8'h6D;
  localparam logic [7:0] OFS_MODE = 8'h6F;
  localparam logic [7:0] OFS_DATA = 8'h70;
  localparam logic [7:0] OFS_LEN  = 8'h71;
  localparam logic [7:0] CMD_ARM  = 8'h80;
  localparam logic [7:0] CMD_GO   = 8'hA0;
  localparam logic [7:0] CMD_OFF  = 8'h00;
  localparam int IW = LW + 2;

  logic [7:0]    adr_hi, adr_mid, adr_lo, op_q;
  logic [LW-1:0] len_q;
  logic          armed, busy, empty;
  logic [LW:0]   fill_ptr;
  logic [IW-1:0] tx_idx;
  logic [7:0]    mem [DEPTH];

  wire           host_wr  = reg_wr && !busy;
  wire           take     = host_wr && reg_addr == OFS_DATA && armed &&
                            fill_ptr <= (LW+1)'(len_q);
  wire [IW-1:0]  last_idx = IW'(len_q) + IW'(4);
  wire [IW-1:0]  mem_idx  = tx_idx - IW'(4);

  always_ff @(posedge clk)
    if (take) mem[fill_ptr[LW-1:0]] <= reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_hi   <= '0;
      adr_mid  <= '0;
      adr_lo   <= '0;
      op_q     <= 8'h02;
      len_q    <= '1;
      armed    <= 1'b0;
      busy     <= 1'b0;
      empty    <= 1'b1;
      fill_ptr <= '0;
      tx_idx   <= '0;
    end else begin
      if (host_wr) begin
        case (reg_addr)
          OFS_A2:  adr_hi  <= reg_wdata;
          OFS_A1:  adr_mid <= reg_wdata;
          OFS_A0:  adr_lo  <= reg_wdata;
          OFS_OP:  op_q    <= reg_wdata;
          OFS_LEN: len_q   <= reg_wdata[LW-1:0];
          OFS_MODE: begin
            if (reg_wdata == CMD_ARM) armed <= 1'b1;
            else if (reg_wdata == CMD_OFF) armed <= 1'b0;
            else if (reg_wdata == CMD_GO && armed) begin
              busy   <= 1'b1;
              tx_idx <= '0;
            end
          end
          default: ;
        endcase
      end
      if (take) begin
        fill_ptr <= fill_ptr + 1'b1;
        empty    <= 1'b0;
      end
      if (busy && spi_tx_ready) begin
        if (tx_idx == last_idx) begin
          busy     <= 1'b0;
          empty    <= 1'b1;
          fill_ptr <= '0;
        end else begin
          tx_idx <= tx_idx + 1'b1;
        end
      end
    end
  end

  assign spi_frame    = busy;
  assign spi_tx_valid = busy;

  always_comb begin
    case (tx_idx)
      IW'(0):  spi_tx_data = op_q;
      IW'(1):  spi_tx_data = adr_hi;
      IW'(2):  spi_tx_data = adr_mid;
      IW'(3):  spi_tx_data = adr_lo;
      default: spi_tx_data = mem[mem_idx[LW-1:0]];
    endcase
  end

  always_comb begin
    case (reg_addr)
      OFS_A2:   reg_rdata = adr_hi;
      OFS_A1:   reg_rdata = adr_mid;
      OFS_A0:   reg_rdata = adr_lo;
      OFS_OP:   reg_rdata = op_q;
      OFS_LEN:  reg_rdata = 8'(len_q);
      OFS_MODE: reg_rdata = {armed, 1'b0, busy, empty, 4'b0000};
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       spi_frame,
  input logic       spi_tx_valid,
  input logic [7:0] spi_tx_data,
  input logic       spi_tx_ready,
  input logic [7:0] op_q,
  input logic [7:0] adr_hi,
  input logic       armed,
  input logic       busy,
  input logic       empty
);
  p_opcode_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_frame) |-> spi_tx_data == op_q);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && !spi_tx_ready |=> spi_tx_valid && $stable(spi_tx_data));

  p_empty_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> empty);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(adr_hi) && $stable(op_q));

  p_no_start_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 8'h6F && reg_wdata == 8'hA0 && !armed && !busy |=> !spi_frame);
endmodule

bind page_prog_buffer page_prog_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .spi_frame(spi_frame), .spi_tx_valid(spi_tx_valid),
  .spi_tx_data(spi_tx_data), .spi_tx_ready(spi_tx_ready), .op_q(op_q),
  .adr_hi(adr_hi), .armed(armed), .busy(busy), .empty(empty)
);

// File: tb/page_prog_buffer_bench.sv
module page_prog_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_frame, spi_tx_valid;
  logic [7:0] spi_tx_data;
  logic       spi_tx_ready = 1'b1;

  page_prog_buffer u_page_prog_buffer (.*);

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0, fb = 0, stalls = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  byte unsigned m_a2, m_a1, m_a0, m_op, m_len;
  bit m_armed, m_busy, m_empty;
  int m_cnt;
  byte unsigned m_buf [256];
  byte unsigned m_q [$];

  function automatic byte unsigned m_read(byte unsigned a);
    case (a)
      8'h64: return m_a2;
      8'h65: return m_a1;
      8'h66: return m_a0;
      8'h6D: return m_op;
      8'h71: return m_len;
      8'h6F: return {m_armed, 1'b0, m_busy, m_empty, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a2 = 0; m_a1 = 0; m_a0 = 0; m_op = 8'h02; m_len = 8'hFF;
      m_armed = 0; m_busy = 0; m_empty = 1; m_cnt = 0; m_q.delete();
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy && spi_tx_ready) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin
          m_busy = 0; m_empty = 1; m_cnt = 0;
        end
      end
      if (reg_wr && !was_busy) begin
        case (reg_addr)
          8'h64: m_a2 = reg_wdata;
          8'h65: m_a1 = reg_wdata;
          8'h66: m_a0 = reg_wdata;
          8'h6D: m_op = reg_wdata;
          8'h71: m_len = reg_wdata;
          8'h70: if (m_armed && m_cnt <= m_len) begin
            m_buf[m_cnt] = reg_wdata; m_cnt++; m_empty = 0;
          end
          8'h6F: begin
            if (reg_wdata == 8'h80) m_armed = 1;
            else if (reg_wdata == 8'h00) m_armed = 0;
            else if (reg_wdata == 8'hA0 && m_armed) begin
              m_busy = 1;
              m_q = {m_op, m_a2, m_a1, m_a0};
              for (int i = 0; i <= m_len; i++) m_q.push_back(m_buf[i]);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (spi_tx_valid && spi_tx_ready) fb++;
    if (spi_tx_valid && !spi_tx_ready) stalls++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0 (cycles left)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
    #2;
    chk(spi_frame == m_busy, "R6 frame", spi_frame, m_busy);
    chk(spi_tx_valid == m_busy, "R6 valid", spi_tx_valid, m_busy);
    if (m_busy) chk(spi_tx_data == m_q[0], "R7 byte", spi_tx_data, m_q[0]);
    chk(reg_rdata == m_read(reg_addr),
        reg_addr == 8'h6F ? "R5 mode" : "R2 reg", reg_rdata, m_read(reg_addr));
  end

  always @(negedge clk) spi_tx_ready <= stall_mode ? (cyc % 3 != 1) : 1'b1;

  task automatic wr(byte unsigned a, byte unsigned d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(byte unsigned a, byte unsigned exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (spi_frame);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd_check(8'h6F, 8'h10, "R1 mode");
    rd_check(8'h71, 8'hFF, "R1 len");
    rd_check(8'h6D, 8'h02, "R1 opcode");
    rd_check(8'h64, 8'h00, "R1 addr");
    chk(!spi_frame, "R1 frame", spi_frame, 0);

    wr(8'h70, 8'h11);
    wr(8'h6F, 8'hA0);
    repeat (3) @(negedge clk);
    rd_check(8'h6F, 8'h10, "R3 unarmed ignores");
    wr(8'h6F, 8'h80);
    rd_check(8'h6F, 8'h90, "R3 armed");

    wr(8'h64, 8'h12); wr(8'h65, 8'h34); wr(8'h66, 8'h00); wr(8'h71, 8'h03);
    rd_check(8'h65, 8'h34, "R2 addr mid");
    for (int i = 0; i < 6; i++) wr(8'h70, 8'hA1 + i);
    rd_check(8'h6F, 8'h80, "R5 not empty");
    stall_mode = 1'b1;
    fb = 0; stalls = 0;
    wr(8'h6F, 8'hA0);
    wr(8'h64, 8'h55);
    wr(8'h70, 8'hEE);
    wr(8'h6F, 8'h00);
    wait_idle();
    chk(fb == 8, "R4 frame length", fb, 8);
    chk(stalls > 0, "R8 stalls seen", stalls, 1);
    rd_check(8'h64, 8'h12, "R9 addr kept");
    rd_check(8'h6F, 8'h90, "R9 mode kept");

    wr(8'h64, 8'h01); wr(8'h65, 8'hAB); wr(8'h71, 8'hFF); wr(8'h6D, 8'h02);
    for (int i = 0; i < 260; i++) wr(8'h70, 8'((i * 7 + 3) & 8'hFF));
    fb = 0;
    wr(8'h6F, 8'hA0);
    wait_idle();
    chk(fb == 260, "R4 full page", fb, 260);
    rd_check(8'h6F, 8'h90, "R5 empty again");

    stall_mode = 1'b0;
    wr(8'h6F, 8'h00);
    rd_check(8'h6F, 8'h10, "R3 disarmed");
    wr(8'h70, 8'h77);
    rd_check(8'h6F, 8'h10, "R3 data ignored");
    wr(8'h6F, 8'h80);
    wr(8'h71, 8'h00); wr(8'h6D, 8'h32);
    wr(8'h70, 8'h5A);
    fb = 0;
    wr(8'h6F, 8'hA0);
    wait_idle();
    chk(fb == 5, "R7 single byte frame", fb, 5);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule